// File: doc/BRIEF.md
# Sequential Radix-4 Booth Multiplier

This block multiplies two signed two's-complement operands of `N` bits over several clock cycles and returns a signed product of `2N` bits. A one-cycle `start` pulse latches both operands. The block then works through the multiplier two bits per step. In each step it reads a three-bit window of the multiplier register and recodes it as one of five actions: add nothing, add or subtract the multiplicand, or add or subtract twice the multiplicand. The chosen multiple goes into a wide accumulator. After that, the accumulator and the multiplier register shift right together by two places, with sign extension.

After `N/2` steps the high half of the product sits in the accumulator and the low half in the multiplier register. At that point `done` rises and `busy` falls. Within a run of ones in the multiplier, every window reads `111` and needs no addition. Only the edges of the run cost an add or a subtract.

Top module: `booth_mul_seq`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `busy` = 0, `done` = 0 and `product` = 0.
- R2: When a run finishes, `product` equals the signed product of the latched `mcand` and `mplier`, sign-extended to `2N` bits.
- R3: If `start` is sampled high while `busy` is low, `busy` is high and `done` low after that edge. `busy` stays high for exactly `N/2` cycles, and after the `N/2`-th further edge `done` = 1 and `busy` = 0.
- R4: A `start` pulse while `busy` is high has no effect. The running product, the operands in use and the finishing cycle are all unchanged.
- R5: `done` and `product` hold their values until the next `start`. A `start` taken while `done` is high clears `done` on the next edge and begins a new run.
- R6: The most negative operand times itself gives `2^(2N-2)`. The most negative operand times the most positive operand gives the correct negative result.
- R7: A zero operand gives 0. A multiplier of 1 gives the multiplicand sign-extended. A multiplier of -1 gives its two's-complement negation.
- R8: Alternating multiplier patterns give the correct product. These are `0101...` (windows `010`, recoded +M) and `1010...` (windows `100`/`101`, recoded -2M/-M).
- R9: The recoding of the window {Q[1], Q[0], Q[-1]} is as follows, where Q[-1] is cleared at start:
  - `000` and `111` select no addition.
  - `001` and `010` select +M.
  - `011` selects +2M.
  - `100` selects -2M.
  - `101` and `110` select -M.
  - A no-addition step never also requests negation or doubling.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a multiplication; ignored while busy |
| mcand | input | N | Multiplicand, two's complement |
| mplier | input | N | Multiplier, two's complement |
| busy | output | 1 | High while iterations are in progress |
| done | output | 1 | High from the end of a run until the next start |
| product | output | 2N | Signed product {accumulator low N bits, multiplier register} |

## Verification
The start edge is the edge at which `start` is sampled. After it, `busy` is due one edge later. `done` and the final `product` are due exactly `N/2` edges after that, with nothing earlier. Each scenario task drives its inputs on a falling edge, counts rising edges from the start edge, and samples outputs only on the following falling edge. It checks that `done` is still low one cycle before the due edge and high on it. The ignore and hold scenarios re-sample `product` and `done` on later falling edges, before the next accepted start, so the checks compare against the schedule and not against whenever the output happens to change.

// File: rtl/booth_pkg.sv
package booth_pkg;

    // Selected action for one radix-4 step
    typedef struct packed {
        logic zero;   // add nothing
        logic dbl;    // use twice the multiplicand
        logic neg;    // subtract instead of add
    } booth_op_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } booth_state_t;

    // Window is {Q[1], Q[0], Q[-1]}
    function automatic booth_op_t booth_recode(input logic [2:0] win);
        booth_op_t op;
        op.zero = (win == 3'b000) || (win == 3'b111);
        op.dbl  = (win == 3'b011) || (win == 3'b100);
        op.neg  = win[2] && !op.zero;
        return op;
    endfunction

endpackage

// File: rtl/booth_recoder.sv
module booth_recoder
    import booth_pkg::*;
(
    input  logic [2:0] win,
    output booth_op_t  op
);
    always_comb op = booth_recode(win);
endmodule

// File: rtl/booth_addsub.sv
module booth_addsub
    import booth_pkg::*;
#(
    parameter int N = 16
) (
    input  logic [N+1:0] acc,
    input  logic [N-1:0] mcand,
    input  booth_op_t    op,
    output logic [N+1:0] sum
);
    localparam int W = N + 2;

    logic [W-1:0] mult;
    logic [W-1:0] operand;

    always_comb begin
        if (op.zero)
            mult = '0;
        else if (op.dbl)
            mult = {mcand[N-1], mcand, 1'b0};
        else
            mult = {{2{mcand[N-1]}}, mcand};
        operand = op.neg ? ~mult : mult;
        sum     = acc + operand + {{(W-1){1'b0}}, op.neg};
    end
endmodule

// File: rtl/booth_ctrl.sv
module booth_ctrl
    import booth_pkg::*;
#(
    parameter int N = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic load,
    output logic step,
    output logic busy,
    output logic done
);
    localparam int STEPS = N / 2;
    localparam int CW    = $clog2(STEPS + 1);

    booth_state_t  state;
    logic [CW-1:0] cnt;

    assign load = start && (state != ST_RUN);
    assign step = (state == ST_RUN);
    assign busy = (state == ST_RUN);
    assign done = (state == ST_DONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else if (load) begin
            state <= ST_RUN;
            cnt   <= CW'(STEPS);
        end else if (state == ST_RUN) begin
            cnt <= cnt - CW'(1);
            if (cnt == CW'(1))
                state <= ST_DONE;
        end
    end
endmodule

// File: rtl/booth_mul_seq.sv
module booth_mul_seq
    import booth_pkg::*;
#(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [N-1:0] mcand,
    input  logic [N-1:0] mplier,
    output logic         busy,
    output logic         done,
    output logic [2*N-1:0] product
);
    localparam int AW = N + 2;

    logic [N-1:0]  m_q;
    logic [AW-1:0] acc_q;
    logic [N-1:0]  q_q;
    logic          qm1_q;
    logic          load;
    logic          step;
    booth_op_t     op;
    logic [AW-1:0] sum;

    booth_ctrl #(.N(N)) u_ctrl (
        .clk  (clk),
        .rst  (rst),
        .start(start),
        .load (load),
        .step (step),
        .busy (busy),
        .done (done)
    );

    booth_recoder u_rec (
        .win({q_q[1], q_q[0], qm1_q}),
        .op (op)
    );

    booth_addsub #(.N(N)) u_add (
        .acc  (acc_q),
        .mcand(m_q),
        .op   (op),
        .sum  (sum)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            m_q   <= '0;
            acc_q <= '0;
            q_q   <= '0;
            qm1_q <= 1'b0;
        end else if (load) begin
            m_q   <= mcand;
            acc_q <= '0;
            q_q   <= mplier;
            qm1_q <= 1'b0;
        end else if (step) begin
            acc_q <= {{2{sum[AW-1]}}, sum[AW-1:2]};
            q_q   <= {sum[1:0], q_q[N-1:2]};
            qm1_q <= q_q[1];
        end
    end

    assign product = {acc_q[N-1:0], q_q};
endmodule

// File: rtl/booth_mul_chk.sv
module booth_mul_chk
    import booth_pkg::*;
#(
    parameter int N = 16
) (
    input logic           clk,
    input logic           rst,
    input logic           start,
    input logic           busy,
    input logic           done,
    input logic [2*N-1:0] product,
    input logic [N-1:0]   m_q,
    input booth_op_t      op
);
    assert_exclusive_R3: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));

    assert_start_takes_R3: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (busy && !done));

    assert_end_flags_done_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    assert_busy_ignores_start_R4: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(m_q));

    assert_done_holds_R5: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> (done && $stable(product)));

    assert_noadd_clean_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && op.zero) |-> (!op.neg && !op.dbl));
endmodule

bind booth_mul_seq booth_mul_chk #(.N(N)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .busy   (busy),
    .done   (done),
    .product(product),
    .m_q    (m_q),
    .op     (op)
);

// File: tb/test_booth_mul_seq.sv
`timescale 1ns/1ps
module test_booth_mul_seq;
    localparam int N     = 16;
    localparam int STEPS = N / 2;

    logic           clk = 1'b0;
    logic           rst;
    logic           start;
    logic [N-1:0]   mcand;
    logic [N-1:0]   mplier;
    logic           busy;
    logic           done;
    logic [2*N-1:0] product;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    booth_mul_seq #(.N(N)) i_booth_mul_seq (
        .clk(clk), .rst(rst), .start(start),
        .mcand(mcand), .mplier(mplier),
        .busy(busy), .done(done), .product(product)
    );

    function automatic logic [2*N-1:0] ref_mul(input logic [N-1:0] a, input logic [N-1:0] b);
        logic signed [2*N-1:0] ea;
        logic signed [2*N-1:0] eb;
        ea = $signed(a);
        eb = $signed(b);
        return ea * eb;
    endfunction

    task automatic check(input string req, input logic [2*N-1:0] act, input logic [2*N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Full run with timing checks; returns on the falling edge after done is due
    task automatic run_mul(input string req, input logic [N-1:0] a, input logic [N-1:0] b);
        @(negedge clk);
        mcand  = a;
        mplier = b;
        start  = 1'b1;
        @(negedge clk);
        start  = 1'b0;
        check({req, "/R3 busy"}, {31'b0, busy}, 1);
        check({req, "/R3 done low"}, {31'b0, done}, 0);
        repeat (STEPS - 1) @(negedge clk);
        check({req, "/R3 early"}, {30'b0, busy, done}, 2'b10);
        @(negedge clk);
        check({req, "/R3 finish"}, {30'b0, busy, done}, 2'b01);
        check(req, product, ref_mul(a, b));
    endtask

    task automatic t_reset;
        rst = 1'b1; start = 1'b0; mcand = '0; mplier = '0;
        repeat (3) @(negedge clk);
        check("R1 flags", {30'b0, busy, done}, 0);
        check("R1 product", product, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after", {30'b0, busy, done}, 0);
    endtask

    task automatic t_corners;
        logic [N-1:0] mn = {1'b1, {(N-1){1'b0}}};
        logic [N-1:0] mx = {1'b0, {(N-1){1'b1}}};
        run_mul("R6 min*min", mn, mn);
        check("R6 value", product, {2'b01, {(2*N-2){1'b0}}});
        run_mul("R6 min*max", mn, mx);
        run_mul("R6 max*max", mx, mx);
        run_mul("R7 x*0", 16'h1234, 16'h0000);
        run_mul("R7 0*x", 16'h0000, 16'hBEEF);
        run_mul("R7 x*1", 16'hC321, 16'h0001);
        run_mul("R7 x*-1", 16'h0F0F, 16'hFFFF);
        run_mul("R7 min*-1", mn, 16'hFFFF);
    endtask

    task automatic t_alternating;
        run_mul("R8 0101", 16'h3A7C, 16'h5555);
        run_mul("R8 1010", 16'h3A7C, 16'hAAAA);
        run_mul("R8 1010 neg", 16'h9001, 16'hAAAA);
        run_mul("R9 ones run", 16'h0123, 16'h0FF0);
    endtask

    task automatic t_random;
        for (int i = 0; i < 40; i++) begin
            logic [N-1:0] a = N'($urandom);
            logic [N-1:0] b = N'($urandom);
            run_mul("R2 random", a, b);
        end
    endtask

    task automatic t_ignore;
        logic [2*N-1:0] exp = ref_mul(16'h7123, 16'h8F01);
        @(negedge clk);
        mcand = 16'h7123; mplier = 16'h8F01; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (2) @(negedge clk);
        mcand = 16'h0001; mplier = 16'h0002; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R4 still busy", {31'b0, busy}, 1);
        repeat (STEPS - 4) @(negedge clk);
        check("R4 not early", {30'b0, busy, done}, 2'b10);
        @(negedge clk);
        check("R4 finish", {30'b0, busy, done}, 2'b01);
        check("R4 product", product, exp);
    endtask

    task automatic t_hold;
        logic [2*N-1:0] exp = ref_mul(16'hFF80, 16'h0203);
        run_mul("R5 first", 16'hFF80, 16'h0203);
        mcand = 16'h1111; mplier = 16'h2222;
        repeat (6) @(negedge clk);
        check("R5 done held", {31'b0, done}, 1);
        check("R5 product held", product, exp);
        run_mul("R5 restart", 16'h1111, 16'h2222);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_corners();
        t_alternating();
        t_ignore();
        t_hold();
        t_random();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule